// File: doc/BRIEF.md
# Precise Exception Tracker for a Five-Stage In-Order Pipeline

This block does the exception bookkeeping for an in-order pipeline with fetch, decode, execute, memory and writeback stages. Every slot that enters the pipeline carries a valid bit, its PC and a 3-bit cause code. A fault that a stage detects is recorded on the instruction it belongs to. The fault is not acted on at that point: the record travels with the instruction, and the block takes the exception only when the instruction is in writeback. Faults can be detected in any order in time. Because only the instruction in writeback is ever taken, the exception taken is always the one on the oldest faulting instruction.

When a faulting slot is in writeback, the block does four things in the same cycle. It asserts the take signal, presents the handler address on the redirect output, and empties every younger stage. At the end of that cycle it loads the exception PC and the cause register. An external interrupt request does not stop the instruction being fetched. Instead, a no-op already marked as faulting replaces the fetched instruction and travels down the pipeline like any other slot. The request is level-sensitive: if the no-op is flushed by an older exception, a new one is inserted once the flush is over. The datapath, forwarding and handler software are outside this block. The pipeline advances by one stage every cycle.

Top module: `exc_pipe`

## Requirements
- R1: After synchronous reset all stages are empty. `exc_take`, `wb_commit` and `mem_store_en` are 0, and `epc` and `exc_cause` are 0.
- R2: A slot presented at fetch in cycle c is in writeback in cycle c+4. If it carries no fault, `wb_commit` is 1 in that cycle and `wb_pc` equals its fetch PC.
- R3: Cause codes are 1 for a fetch translation fault (`itlb_fault` with the slot at fetch), 2 for an illegal instruction (`id_illegal` in cycle c+1), 3 for an overflow (`ex_ovf` in c+2), 4 for a data translation fault (`mem_dtlb` in c+3), 5 for an interrupt and 0 for none.
- R4: When one instruction sees faults in several stages, the cause taken is that of the earliest stage. A later stage never overwrites a recorded cause.
- R5: `exc_take` is 1 only in the cycle a faulting slot is in writeback. In that cycle `exc_vector` equals the VECTOR parameter and `wb_commit` is 0.
- R6: At the clock edge that ends a take cycle, `epc` and `exc_cause` load the PC and cause of the slot in writeback. At all other edges they hold their value.
- R7: A take empties the decode, execute and memory stages and drops the slot at fetch. None of these slots ever commits or raises a take.
- R8: Instructions older than the faulting one complete and commit, even if a younger instruction raised its fault earlier in time. The exception taken is the oldest one.
- R9: `mem_store_en` equals `mem_is_store` for a fault-free slot in the memory stage. It is 0 if the slot already carries a cause, if `mem_dtlb` is 1, or if `exc_take` is 1.
- R10: When `irq` is 1 and no interrupt no-op is in flight, the fetch slot becomes an interrupt no-op (cause 5) with PC equal to `fetch_pc`. The fetched instruction is discarded, and at most one interrupt no-op is in flight.
- R11: A held `irq` whose no-op was flushed by an older exception is inserted again in the first cycle after the take. It is then taken 4 cycles after that.
- R12: `id_illegal`, `ex_ovf`, `mem_dtlb` and `mem_is_store` have no effect while the corresponding stage is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_valid | input | 1 | An instruction is fetched this cycle |
| fetch_pc | input | PC_W | PC of the fetch slot |
| itlb_fault | input | 1 | Fetch translation fault for the fetch slot |
| irq | input | 1 | Level-held external interrupt request |
| id_illegal | input | 1 | Decode stage instruction is illegal |
| ex_ovf | input | 1 | Execute stage arithmetic overflow |
| mem_dtlb | input | 1 | Memory stage data translation fault |
| mem_is_store | input | 1 | Memory stage instruction is a store |
| exc_take | output | 1 | Exception taken this cycle |
| exc_vector | output | PC_W | Handler address for the fetch redirect |
| epc | output | PC_W | Saved exception PC |
| exc_cause | output | 3 | Saved exception cause |
| wb_commit | output | 1 | Writeback slot commits its state |
| wb_pc | output | PC_W | PC of the writeback slot |
| mem_store_en | output | 1 | Store write permitted this cycle |

## Verification
Each result falls a fixed number of cycles after the stimulus that causes it. A slot fetched in cycle c reaches the memory-stage store check in c+3. Its commit or take appears combinationally in c+4, and the saved `epc` and `exc_cause` are visible from c+5. The bench drives each fault input in the cycle its stage holds the target slot. It changes inputs just after the rising edge and samples outputs at the falling edge of the cycle in which the result is due. Checks that something did not happen, such as squashed slots never committing, are repeated over every cycle in which a slot that should have been squashed would otherwise have reached writeback.

// File: rtl/exc_pkg.sv
package exc_pkg;

    typedef enum logic [2:0] {
        C_NONE = 3'd0,
        C_ITLB = 3'd1,
        C_ILL  = 3'd2,
        C_OVF  = 3'd3,
        C_DTLB = 3'd4,
        C_IRQ  = 3'd5
    } cause_e;

    typedef struct packed {
        logic   valid;
        cause_e cause;
    } slot_st_t;

    localparam int N_STAGE_REGS = 4;

    // fault code detected by the logic that reads stage register i
    function automatic cause_e stage_code(input int idx);
        case (idx)
            0:       return C_ILL;
            1:       return C_OVF;
            2:       return C_DTLB;
            default: return C_NONE;
        endcase
    endfunction

    // first recorded cause wins
    function automatic cause_e merge_cause(input cause_e cur, input logic hit, input cause_e code);
        return (cur == C_NONE && hit) ? code : cur;
    endfunction

endpackage

// File: rtl/exc_inject.sv
module exc_inject
    import exc_pkg::*;
#(
    parameter int PC_W = 32
) (
    input  logic            take,
    input  logic            irq,
    input  logic            irq_busy,
    input  logic            fetch_valid,
    input  logic            itlb_fault,
    input  logic [PC_W-1:0] fetch_pc,
    output slot_st_t        slot_st,
    output logic [PC_W-1:0] slot_pc
);
    always_comb begin
        slot_pc = fetch_pc;
        slot_st = '0;
        if (take) begin
            slot_st = '0;
        end else if (irq && !irq_busy) begin
            slot_st.valid = 1'b1;
            slot_st.cause = C_IRQ;
        end else if (fetch_valid) begin
            slot_st.valid = 1'b1;
            slot_st.cause = itlb_fault ? C_ITLB : C_NONE;
        end
    end
endmodule

// File: rtl/exc_stage.sv
module exc_stage
    import exc_pkg::*;
#(
    parameter int     PC_W = 32,
    parameter cause_e CODE = C_NONE
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            flush,
    input  slot_st_t        in_st,
    input  logic [PC_W-1:0] in_pc,
    input  logic            fault,
    output slot_st_t        raw_st,
    output slot_st_t        tag_st,
    output logic [PC_W-1:0] pc_q
);
    slot_st_t st_q;

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            st_q <= '0;
            pc_q <= '0;
        end else begin
            st_q <= in_st;
            pc_q <= in_pc;
        end
    end

    always_comb begin
        raw_st       = st_q;
        tag_st       = st_q;
        if (st_q.valid)
            tag_st.cause = merge_cause(st_q.cause, fault, CODE);
    end
endmodule

// File: rtl/exc_commit.sv
module exc_commit
    import exc_pkg::*;
#(
    parameter int              PC_W   = 32,
    parameter logic [PC_W-1:0] VECTOR = '0
) (
    input  logic            clk,
    input  logic            rst,
    input  slot_st_t        wb_st,
    input  logic [PC_W-1:0] wb_slot_pc,
    output logic            take,
    output logic            commit,
    output logic [PC_W-1:0] vector,
    output logic [PC_W-1:0] epc_q,
    output logic [2:0]      cause_q
);
    assign take   = wb_st.valid && (wb_st.cause != C_NONE);
    assign commit = wb_st.valid && (wb_st.cause == C_NONE);
    assign vector = VECTOR;

    always_ff @(posedge clk) begin
        if (rst) begin
            epc_q   <= '0;
            cause_q <= '0;
        end else if (take) begin
            epc_q   <= wb_slot_pc;
            cause_q <= wb_st.cause;
        end
    end
endmodule

// File: rtl/exc_pipe.sv
module exc_pipe
    import exc_pkg::*;
#(
    parameter int              PC_W   = 32,
    parameter logic [PC_W-1:0] VECTOR = 32'h0000_0080
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            fetch_valid,
    input  logic [PC_W-1:0] fetch_pc,
    input  logic            itlb_fault,
    input  logic            irq,
    input  logic            id_illegal,
    input  logic            ex_ovf,
    input  logic            mem_dtlb,
    input  logic            mem_is_store,
    output logic            exc_take,
    output logic [PC_W-1:0] exc_vector,
    output logic [PC_W-1:0] epc,
    output logic [2:0]      exc_cause,
    output logic            wb_commit,
    output logic [PC_W-1:0] wb_pc,
    output logic            mem_store_en
);
    localparam int NS     = N_STAGE_REGS;
    localparam int MEM_IX = NS - 2;
    localparam int WB_IX  = NS - 1;

    slot_st_t          inj_st;
    logic [PC_W-1:0]   inj_pc;
    slot_st_t          st_in  [NS];
    logic [PC_W-1:0]   pc_in  [NS];
    slot_st_t          st_raw [NS];
    slot_st_t          st_tag [NS];
    logic [PC_W-1:0]   st_pc  [NS];
    logic [NS-1:0]     faults;
    logic [NS-1:0]     irq_here;
    logic              irq_busy;

    assign faults = {1'b0, mem_dtlb, ex_ovf, id_illegal};

    exc_inject #(.PC_W(PC_W)) u_inject (
        .take        (exc_take),
        .irq         (irq),
        .irq_busy    (irq_busy),
        .fetch_valid (fetch_valid),
        .itlb_fault  (itlb_fault),
        .fetch_pc    (fetch_pc),
        .slot_st     (inj_st),
        .slot_pc     (inj_pc)
    );

    for (genvar i = 0; i < NS; i++) begin : g_stage
        if (i == 0) begin : g_head
            assign st_in[i] = inj_st;
            assign pc_in[i] = inj_pc;
        end else begin : g_link
            assign st_in[i] = st_tag[i-1];
            assign pc_in[i] = st_pc[i-1];
        end

        exc_stage #(.PC_W(PC_W), .CODE(stage_code(i))) u_stage (
            .clk    (clk),
            .rst    (rst),
            .flush  (exc_take),
            .in_st  (st_in[i]),
            .in_pc  (pc_in[i]),
            .fault  (faults[i]),
            .raw_st (st_raw[i]),
            .tag_st (st_tag[i]),
            .pc_q   (st_pc[i])
        );

        assign irq_here[i] = st_raw[i].valid && (st_raw[i].cause == C_IRQ);
    end

    assign irq_busy = |irq_here;

    exc_commit #(.PC_W(PC_W), .VECTOR(VECTOR)) u_commit (
        .clk        (clk),
        .rst        (rst),
        .wb_st      (st_raw[WB_IX]),
        .wb_slot_pc (st_pc[WB_IX]),
        .take       (exc_take),
        .commit     (wb_commit),
        .vector     (exc_vector),
        .epc_q      (epc),
        .cause_q    (exc_cause)
    );

    assign wb_pc        = st_pc[WB_IX];
    assign mem_store_en = mem_is_store && st_tag[MEM_IX].valid &&
                          (st_tag[MEM_IX].cause == C_NONE) && !exc_take;
endmodule

// File: rtl/exc_pipe_chk.sv
module exc_pipe_chk #(
    parameter int PC_W = 32
) (
    input logic            clk,
    input logic            rst,
    input logic            exc_take,
    input logic            wb_commit,
    input logic [PC_W-1:0] wb_pc,
    input logic [PC_W-1:0] epc,
    input logic [2:0]      exc_cause,
    input logic            mem_store_en,
    input logic            mem_dtlb
);
    // R5: a take and a commit never share a cycle
    p_take_no_commit_r5: assert property (@(posedge clk) disable iff (rst)
        exc_take |-> !wb_commit);

    // R6: saved PC follows the writeback slot of the take cycle
    p_epc_load_r6: assert property (@(posedge clk) disable iff (rst)
        exc_take |=> (epc == $past(wb_pc)) && (exc_cause != 3'd0));

    // R6: saved state holds when nothing is taken
    p_epc_hold_r6: assert property (@(posedge clk) disable iff (rst)
        !exc_take |=> $stable(epc) && $stable(exc_cause));

    // R7: the cycle after a take, writeback is empty
    p_squash_r7: assert property (@(posedge clk) disable iff (rst)
        exc_take |=> !exc_take && !wb_commit);

    // R9: no store write while taking or on a data translation fault
    p_store_block_r9: assert property (@(posedge clk) disable iff (rst)
        (exc_take || mem_dtlb) |-> !mem_store_en);
endmodule

bind exc_pipe exc_pipe_chk #(.PC_W(PC_W)) u_exc_pipe_chk (
    .clk          (clk),
    .rst          (rst),
    .exc_take     (exc_take),
    .wb_commit    (wb_commit),
    .wb_pc        (wb_pc),
    .epc          (epc),
    .exc_cause    (exc_cause),
    .mem_store_en (mem_store_en),
    .mem_dtlb     (mem_dtlb)
);

// File: tb/tb_exc_pipe.sv
`timescale 1ns/1ps
module tb_exc_pipe;
    localparam int          PC_W = 32;
    localparam logic [31:0] VEC  = 32'h0000_0080;

    logic            clk = 1'b0;
    logic            rst;
    logic            fetch_valid, itlb_fault, irq, id_illegal, ex_ovf, mem_dtlb, mem_is_store;
    logic [PC_W-1:0] fetch_pc;
    logic            exc_take, wb_commit, mem_store_en;
    logic [PC_W-1:0] exc_vector, epc, wb_pc;
    logic [2:0]      exc_cause;

    int n_chk = 0;
    int n_err = 0;

    always #2.5 clk = ~clk;

    exc_pipe #(.PC_W(PC_W), .VECTOR(VEC)) dut (
        .clk(clk), .rst(rst), .fetch_valid(fetch_valid), .fetch_pc(fetch_pc),
        .itlb_fault(itlb_fault), .irq(irq), .id_illegal(id_illegal), .ex_ovf(ex_ovf),
        .mem_dtlb(mem_dtlb), .mem_is_store(mem_is_store), .exc_take(exc_take),
        .exc_vector(exc_vector), .epc(epc), .exc_cause(exc_cause),
        .wb_commit(wb_commit), .wb_pc(wb_pc), .mem_store_en(mem_store_en)
    );

    task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic clear_in();
        fetch_valid = 0; itlb_fault = 0; id_illegal = 0;
        ex_ovf = 0; mem_dtlb = 0; mem_is_store = 0;
    endtask

    // advance to just after the next rising edge; faults default low
    task automatic next();
        @(posedge clk); #1;
        clear_in();
    endtask

    task automatic samp();
        @(negedge clk);
    endtask

    initial begin
        #(5.0 * 150000);
        n_err++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        rst = 1; irq = 0; fetch_pc = '0; clear_in();
        repeat (3) @(posedge clk);
        #1;
        // R1: reset state
        samp();
        chk("R1", "take", exc_take, 0);
        chk("R1", "commit", wb_commit, 0);
        chk("R1", "store", mem_store_en, 0);
        chk("R1", "epc", epc, 0);
        chk("R1", "cause", exc_cause, 0);
        next(); rst = 0;

        // R12: fault inputs with an empty pipeline
        for (int k = 0; k < 6; k++) begin
            next();
            id_illegal = 1; ex_ovf = 1; mem_dtlb = 1; mem_is_store = 1;
            samp();
            chk("R12", "store on empty", mem_store_en, 0);
            chk("R12", "take on empty", exc_take, 0);
        end
        next(); samp();
        chk("R12", "cause untouched", exc_cause, 0);

        // sweep of fault combinations on a single instruction (R2 R3 R4 R5 R6 R9)
        for (int m = 0; m < 16; m++) begin
            logic [31:0] pc;
            logic [2:0]  exp_c;
            pc    = 32'h1000 + 32'(m) * 16;
            exp_c = m[0] ? 3'd1 : m[1] ? 3'd2 : m[2] ? 3'd3 : 3'd4;
            repeat (6) next();
            next(); fetch_valid = 1; fetch_pc = pc; itlb_fault = m[0];
            next(); id_illegal = m[1];
            next(); ex_ovf = m[2];
            next(); mem_dtlb = m[3]; mem_is_store = 1;
            samp();
            chk("R9", "store gated by tag", mem_store_en, (m == 0));
            next(); samp();
            if (m == 0) begin
                chk("R2", "commit", wb_commit, 1);
                chk("R2", "wb pc", wb_pc, pc);
                chk("R5", "no take", exc_take, 0);
            end else begin
                chk("R5", "take", exc_take, 1);
                chk("R5", "vector", exc_vector, VEC);
                chk("R5", "no commit", wb_commit, 0);
            end
            next(); samp();
            chk("R7", "single take", exc_take, 0);
            if (m != 0) begin
                chk("R6", "epc", epc, pc);
                if ((m & (m - 1)) != 0) chk("R4", "first cause", exc_cause, exp_c);
                else                    chk("R3", "cause code", exc_cause, exp_c);
            end
        end

        // R8 R7: younger itlb fault earlier in time, older overflow taken
        repeat (6) next();
        for (int c = 0; c < 12; c++) begin
            next();
            if (c <= 6) begin fetch_valid = 1; fetch_pc = 32'h2000 + 32'(c) * 4; end
            if (c == 3) itlb_fault = 1;          // slot 3, younger
            if (c == 4) ex_ovf = 1;              // slot 2 in execute
            if (c >= 4 && c <= 6) mem_is_store = 1;
            samp();
            case (c)
                4: begin
                    chk("R8", "older commit 0", wb_commit, 1);
                    chk("R8", "older pc 0", wb_pc, 32'h2000);
                    chk("R9", "older store", mem_store_en, 1);
                end
                5: begin
                    chk("R8", "older commit 1", wb_commit, 1);
                    chk("R9", "tagged store", mem_store_en, 0);
                end
                6: begin
                    chk("R8", "oldest taken", exc_take, 1);
                    chk("R9", "store during take", mem_store_en, 0);
                end
                7: begin
                    chk("R8", "cause ovf", exc_cause, 3);
                    chk("R8", "epc slot2", epc, 32'h2008);
                end
                default: ;
            endcase
            if (c >= 7) begin
                chk("R7", "no commit after squash", wb_commit, 0);
                chk("R7", "no take after squash", exc_take, 0);
            end
        end

        // R10: interrupt no-op replaces fetched instruction
        repeat (6) next();
        for (int c = 0; c < 10; c++) begin
            next();
            irq = (c <= 4);
            if (c <= 3) begin fetch_valid = 1; fetch_pc = 32'h3000 + 32'(c) * 4; end
            samp();
            if (c == 4) begin
                chk("R10", "irq take", exc_take, 1);
                chk("R10", "irq no commit", wb_commit, 0);
            end
            if (c == 5) begin
                chk("R10", "irq cause", exc_cause, 5);
                chk("R10", "irq epc", epc, 32'h3000);
            end
            if (c >= 5) begin
                chk("R10", "single irq slot", exc_take, 0);
                chk("R10", "younger dropped", wb_commit, 0);
            end
        end

        // R11: flushed interrupt no-op inserted again
        repeat (6) next();
        for (int c = 0; c < 12; c++) begin
            next();
            irq = (c >= 1 && c <= 5);
            fetch_valid = 1; fetch_pc = 32'h4000 + 32'(c) * 4;
            if (c == 0) itlb_fault = 1;
            samp();
            if (c == 4) chk("R11", "older fault taken", exc_take, 1);
            if (c == 5) chk("R11", "older cause", exc_cause, 1);
            if (c >= 5 && c <= 8) chk("R11", "quiet gap", exc_take, 0);
            if (c == 9) chk("R11", "reinserted take", exc_take, 1);
            if (c == 10) begin
                chk("R11", "reinserted cause", exc_cause, 5);
                chk("R11", "reinserted epc", epc, 32'h4014);
            end
        end
        irq = 0;

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule